// File: doc/BRIEF.md
# Infrared SIR pulse codec

This block joins a UART to an infrared transceiver over a half-duplex serial infrared link. In transmit mode it watches the UART transmit line, takes one bit per bit cell, and sends a short high pulse on the infrared transmit line for every 0 bit. A 1 bit leaves the line dark. In receive mode it watches the infrared receive line through a synchronizer. Each rising edge it sees is turned into a low UART bit of one full cell length.

A bit cell is sixteen ticks of a baud clock enable that runs at sixteen times the bit rate. The enable comes from an outside baud generator. A single mode input selects the direction. While receiving, the transmitter is held dark. While transmitting, the UART receive line is held idle high, so the UART never hears its own frame.

Top module: `irsir_codec`

## Requirements
- R1: While the synchronous active-high reset is asserted, ir_txd is 0 and uart_rxd is 1.
- R2: With rx_mode=0, a bit cell whose latched bit is 1 keeps ir_txd at 0 for all 16 ticks.
- R3: With rx_mode=0, a bit cell whose latched bit is 0 drives ir_txd high from the tick edge of slot 7 until the tick edge of slot 10. Slots are numbered 0 to 15 within the cell, so the pulse is exactly 3 ticks wide, and ir_txd is 0 in the rest of the cell.
- R4: uart_txd is sampled only on the slot-0 tick of each cell. A change of uart_txd later in the cell does not alter that cell's output on ir_txd.
- R5: The slot counter advances once per tick_en, wraps from 15 to 0 and restarts at slot 0 on the first tick after rx_mode returns to 0. Consecutive cells therefore follow without gaps, and every 0 bit of a frame, the start bit included, yields one pulse.
- R6: With rx_mode=1, ir_txd stays 0 whatever uart_txd does (half duplex).
- R7: With rx_mode=1, a rising edge on ir_rxd drives uart_rxd to 0 on the third clock edge after the edge. uart_rxd stays 0 through 15 further ticks and returns to 1 on the 16th tick.
- R8: A rising edge on ir_rxd while uart_rxd is already low is ignored and does not extend the low period.
- R9: With rx_mode=0, uart_rxd stays 1 whatever ir_rxd does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Baud enable, one pulse per sixteenth of a bit |
| rx_mode | input | 1 | 1 selects receive decoding, 0 selects transmit encoding |
| uart_txd | input | 1 | Transmit line from the UART |
| ir_rxd | input | 1 | Receive line from the infrared transceiver |
| ir_txd | output | 1 | Pulse output to the infrared transceiver |
| uart_rxd | output | 1 | Decoded receive line to the UART |

## Verification
The bench builds the codec with its default values: 16 ticks per cell, a pulse starting at slot 7 and lasting 3 ticks, and a two-stage synchronizer. It drives tick_en on every fourth clock. Because of that spacing, counting ticks and counting clocks give different results, so a codec that times the pulse or the low receive period in clocks instead of ticks shows up as wrong. The three-clock receive latency checked in R7 is reachable only with the two-stage synchronizer.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  typedef enum logic {
    MODE_TX = 1'b0,
    MODE_RX = 1'b1
  } link_mode_t;
endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/irsir_encoder.sv
module irsir_encoder #(
  parameter int TICKS  = 16,
  parameter int PSTART = 7,
  parameter int PLEN   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic enc_en,
  input  logic txd,
  output logic ir_txd
);
  localparam int CW   = $clog2(TICKS);
  localparam int PEND = PSTART + PLEN;

  logic [CW-1:0] slot;
  logic          bit_q;
  logic          cur_bit;
  logic          in_win;

  always_comb begin
    cur_bit = (slot == '0) ? txd : bit_q;
    in_win  = (slot >= CW'(PSTART)) && (slot < CW'(PEND));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      bit_q  <= 1'b1;
      ir_txd <= 1'b0;
    end else if (!enc_en) begin
      slot   <= '0;
      bit_q  <= 1'b1;
      ir_txd <= 1'b0;
    end else if (tick_en) begin
      slot   <= (slot == CW'(TICKS-1)) ? '0 : slot + 1'b1;
      if (slot == '0) bit_q <= txd;
      ir_txd <= !cur_bit && in_win;
    end
  end

  // R6: no light while decoding
  p_dark_in_rx_r6: assert property (@(posedge clk) disable iff (rst)
    !enc_en |=> !ir_txd);
  // R3: pulse begins at the slot-7 tick
  p_pulse_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_txd) |-> slot == CW'((PSTART + 1) % TICKS));
  // R3: pulse ends after its length unless the mode changed
  p_pulse_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ir_txd) && $past(enc_en) |-> slot == CW'((PEND + 1) % TICKS));
  // R5: slot only moves on a tick
  p_slot_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $past(enc_en) && enc_en && !$stable(slot) |-> $past(tick_en));
endmodule

// File: rtl/irsir_decoder.sv
module irsir_decoder #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic dec_en,
  input  logic ir_s,
  output logic uart_rxd
);
  localparam int CW = $clog2(TICKS);

  logic          prev;
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      uart_rxd <= 1'b1;
    end else begin
      prev <= ir_s;
      if (!dec_en) begin
        busy     <= 1'b0;
        cnt      <= '0;
        uart_rxd <= 1'b1;
      end else if (busy) begin
        if (tick_en) begin
          if (cnt == CW'(TICKS-1)) begin
            busy     <= 1'b0;
            cnt      <= '0;
            uart_rxd <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (ir_s && !prev) begin
        busy     <= 1'b1;
        cnt      <= '0;
        uart_rxd <= 1'b0;
      end
    end
  end

  // R9: idle high while encoding
  p_idle_in_tx_r9: assert property (@(posedge clk) disable iff (rst)
    !dec_en |=> uart_rxd);
  // R7: low period only begins in receive mode
  p_low_only_rx_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(uart_rxd) |-> $past(dec_en));
  // R7: low period ends on a tick
  p_release_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(uart_rxd) && $past(dec_en) |-> $past(tick_en));
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_START   = 7,
  parameter int PULSE_LEN     = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic rx_mode,
  input  logic uart_txd,
  input  logic ir_rxd,
  output logic ir_txd,
  output logic uart_rxd
);
  link_mode_t mode;
  logic       ir_s;

  assign mode = link_mode_t'(rx_mode);

  irsir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ir_rxd), .q(ir_s)
  );

  irsir_encoder #(
    .TICKS(TICKS_PER_BIT), .PSTART(PULSE_START), .PLEN(PULSE_LEN)
  ) u_enc (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .enc_en(mode == MODE_TX), .txd(uart_txd), .ir_txd(ir_txd)
  );

  irsir_decoder #(.TICKS(TICKS_PER_BIT)) u_dec (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .dec_en(mode == MODE_RX), .ir_s(ir_s), .uart_rxd(uart_rxd)
  );

  // R6: never transmitting and receiving at once
  p_half_duplex_r6: assert property (@(posedge clk) disable iff (rst)
    !(ir_txd && !uart_rxd));
endmodule

// File: tb/irsir_codec_bench.sv
module irsir_codec_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic rx_mode = 1'b0;
  logic uart_txd = 1'b1;
  logic ir_rxd = 1'b0;
  logic ir_txd, uart_rxd;

  int checks = 0;
  int errors = 0;
  int tick_count = 0;
  int divcnt = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    divcnt  = (divcnt + 1) % 4;
    tick_en = (divcnt == 0);
  end

  always @(posedge clk) if (tick_en) tick_count <= tick_count + 1;

  irsir_codec u_irsir_codec (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rx_mode(rx_mode),
    .uart_txd(uart_txd), .ir_rxd(ir_rxd), .ir_txd(ir_txd), .uart_rxd(uart_rxd)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_tick;
    do @(posedge clk); while (!tick_en);
    @(negedge clk);
  endtask

  task automatic wait_ticks_to(input int target);
    while (tick_count < target) @(negedge clk);
  endtask

  task automatic realign;
    rx_mode = 1'b1;
    @(negedge clk);
    rx_mode = 1'b0;
  endtask

  // one bit cell; flip_at >= 0 toggles uart_txd after that slot
  task automatic send_cell(input logic b, input int flip_at, input string req);
    uart_txd = b;
    for (int k = 0; k < 16; k++) begin
      wait_tick();
      chk(req, ir_txd, (!b && k >= 7 && k <= 9));
      if (k == flip_at) uart_txd = ~b;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 ir_txd", ir_txd, 1'b0);
    chk("R1 uart_rxd", uart_rxd, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_one_bit;   realign(); send_cell(1'b1, -1, "R2"); endtask
  task automatic t_zero_bit;  realign(); send_cell(1'b0, -1, "R3"); endtask

  task automatic t_mid_change;
    realign();
    send_cell(1'b0, 3, "R4 zero");
    send_cell(1'b1, 0, "R4 one");
    send_cell(1'b1, 12, "R4 late");
  endtask

  task automatic t_frame;
    logic [7:0] byte_v = 8'hA5;
    realign();
    send_cell(1'b0, -1, "R5 start");
    for (int i = 0; i < 8; i++) send_cell(byte_v[i], -1, "R5 data");
    send_cell(1'b1, -1, "R5 stop");
  endtask

  task automatic t_rx_dark;
    rx_mode = 1'b1;
    for (int k = 0; k < 40; k++) begin
      uart_txd = k[2];
      wait_tick();
      chk("R6", ir_txd, 1'b0);
    end
    realign();
    send_cell(1'b0, -1, "R5 restart");
  endtask

  task automatic pulse_ir;
    ir_rxd = 1'b1;
    repeat (12) @(negedge clk);
    ir_rxd = 1'b0;
  endtask

  task automatic t_decode(input logic retrigger, input string req);
    int start;
    rx_mode = 1'b1;
    repeat (4) @(negedge clk);
    ir_rxd = 1'b1;
    repeat (2) @(negedge clk);
    chk({req, " early"}, uart_rxd, 1'b1);
    @(negedge clk);
    chk({req, " low"}, uart_rxd, 1'b0);
    start = tick_count;
    repeat (9) @(negedge clk);
    ir_rxd = 1'b0;
    if (retrigger) begin
      wait_ticks_to(start + 6);
      pulse_ir();
    end
    wait_ticks_to(start + 15);
    chk({req, " hold"}, uart_rxd, 1'b0);
    wait_ticks_to(start + 16);
    chk({req, " release"}, uart_rxd, 1'b1);
  endtask

  task automatic t_tx_ignore;
    rx_mode = 1'b0;
    uart_txd = 1'b1;
    for (int n = 0; n < 3; n++) begin
      ir_rxd = 1'b1;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        chk("R9", uart_rxd, 1'b1);
        if (c == 10) ir_rxd = 1'b0;
      end
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_one_bit();
        t_zero_bit();
        t_mid_change();
        t_frame();
        t_rx_dark();
        t_decode(1'b0, "R7");
        t_decode(1'b1, "R8");
        t_tx_ignore();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule